// File: doc/BRIEF.md
# Compressed Line Offset Calculator

This block locates one cache line inside a compressed 4KB page. The page holds 64 lines of 64B each. Each line is stored in one of four size bins, and a metadata entry holds a 2-bit bin code per line. Given that entry and a line index, the block adds up the stored sizes of every line ahead of the target and returns the byte offset of the target inside the page. It also returns the stored size of the target line.

Each bin size is divided by eight before the addition, so every addend is 0, 1, 4 or 8. A masked, balanced adder tree reduces all the addends in one combinational pass. One register stage holds the result. A caller pulses `start_i` together with the metadata and index. The offset, the size and a one-cycle `valid_o` pulse appear in the next cycle. The registered results stay in place until the next start.

Top module: `cline_offset_calc`

## Requirements
- R1: `size_o` is the stored byte size of the target line. Line i's code sits at `codes_i[2i+1:2i]`, and the codes mean 2'b00 = 0B, 2'b01 = 8B, 2'b10 = 32B and 2'b11 = 64B.
- R2: `offset_o` equals the sum of the byte sizes of lines 0 to index-1, with each line decoded as in R1.
- R3: When the index is 0, `offset_o` is 0 whatever the codes are.
- R4: `valid_o` is high for exactly the one cycle after each cycle in which `start_i` is sampled high, and low otherwise.
- R5: `offset_o` and `size_o` take new values only in the cycle after a start, and otherwise hold their previous values.
- R6: `offset_o` is always a multiple of 8 and never exceeds index×64. A page with every line at 64B and index 63 gives 4032.
- R7: The codes of the target line and of the lines after it have no effect on `offset_o`.
- R8: While `rst_n` is sampled low, `valid_o`, `offset_o` and `size_o` all clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request strobe, one cycle |
| codes_i | input | 128 | Packed size codes, 2 bits per line, line 0 in the low bits |
| index_i | input | 6 | Target line index |
| valid_o | output | 1 | Result pulse, the cycle after start |
| offset_o | output | 12 | Byte offset of the target line |
| size_o | output | 7 | Stored byte size of the target line |

## Verification
All three results and the valid pulse are due exactly one clock edge after `start_i` is sampled. The bench drives its inputs on the falling edge and raises start for one cycle. It reads the results at the following falling edge, which lies half a period after the capturing edge. One cycle later it checks that valid has dropped and that the offset and size have not moved. The expected values come from a plain loop over the lines before the target. The bench tries every index under random code vectors, then directed pages (all empty, all full, alternating) and a perturbation of the lines at and above the target.

// File: rtl/cloc_pkg.sv
// Package: shared size-code type and scaling helpers for the compressed
// line offset calculator. Assumes four bins of 0, 8, 32 and 64 bytes.
package cloc_pkg;

    typedef enum logic [1:0] {
        BIN_EMPTY = 2'b00,
        BIN_8B    = 2'b01,
        BIN_32B   = 2'b10,
        BIN_64B   = 2'b11
    } bin_code_e;

    localparam int unsigned ADDEND_W = 4;  // scaled bin size fits 0..8
    localparam int unsigned BYTES_W  = 7;  // byte size fits 0..64

    // Bin size divided by eight: the addend fed to the summing tree.
    function automatic logic [ADDEND_W-1:0] bin_scaled(input logic [1:0] code);
        case (bin_code_e'(code))
            BIN_EMPTY: bin_scaled = 4'd0;
            BIN_8B:    bin_scaled = 4'd1;
            BIN_32B:   bin_scaled = 4'd4;
            default:   bin_scaled = 4'd8;
        endcase
    endfunction

    // Bin size in bytes, reported for the target line.
    function automatic logic [BYTES_W-1:0] bin_bytes(input logic [1:0] code);
        bin_bytes = {bin_scaled(code), 3'b000};
    endfunction

endpackage

// File: rtl/cloc_mask_decode.sv
// Module: cloc_mask_decode
// Turns each line's size code into its scaled addend. It zeroes the addend
// of every line whose position is at or after the target index. Purely
// combinational. Assumes the codes are packed two bits per line, line 0 in
// the low bits.
module cloc_mask_decode
    import cloc_pkg::*;
#(
    parameter int unsigned LINES = 64
) (
    input  logic [2*LINES-1:0]        codes_i,
    input  logic [$clog2(LINES)-1:0]  index_i,
    output logic [ADDEND_W*LINES-1:0] addends_o
);
    localparam int unsigned IDX_W = $clog2(LINES);

    // One decoder per line: keep the addend only for lines before the target.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic before_target;
        assign before_target = (IDX_W'(i) < index_i);
        assign addends_o[ADDEND_W*i +: ADDEND_W] =
            before_target ? bin_scaled(codes_i[2*i +: 2]) : '0;
    end

endmodule

// File: rtl/cloc_adder_tree.sv
// Module: cloc_adder_tree
// Balanced binary reduction of LINES narrow addends into one sum. Leaves are
// padded with zeros up to a power of two. Assumes SUM_W is wide enough for
// LINES times the largest addend.
module cloc_adder_tree
    import cloc_pkg::*;
#(
    parameter int unsigned LINES = 64,
    parameter int unsigned SUM_W = 9
) (
    input  logic [ADDEND_W*LINES-1:0] addends_i,
    output logic [SUM_W-1:0]          sum_o
);
    localparam int unsigned DEPTH  = $clog2(LINES);
    localparam int unsigned LEAVES = 1 << DEPTH;

    // Level 0 holds the leaves; level l+1 adds adjacent pairs of level l.
    for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
        localparam int unsigned NODES = LEAVES >> l;
        logic [SUM_W-1:0] part [NODES];
        if (l == 0) begin : g_leaf
            for (genvar j = 0; j < NODES; j++) begin : g_node
                if (j < LINES) begin : g_real
                    assign part[j] = SUM_W'(addends_i[ADDEND_W*j +: ADDEND_W]);
                end else begin : g_pad
                    assign part[j] = '0;
                end
            end
        end else begin : g_sum
            for (genvar j = 0; j < NODES; j++) begin : g_node
                assign part[j] = g_lvl[l-1].part[2*j] + g_lvl[l-1].part[2*j+1];
            end
        end
    end

    // The root of the tree is the total.
    assign sum_o = g_lvl[DEPTH].part[0];

endmodule

// File: rtl/cloc_size_select.sv
// Module: cloc_size_select
// Selects the target line's code and expands it to a byte size.
// Combinational. Assumes the index is below LINES.
module cloc_size_select
    import cloc_pkg::*;
#(
    parameter int unsigned LINES = 64
) (
    input  logic [2*LINES-1:0]       codes_i,
    input  logic [$clog2(LINES)-1:0] index_i,
    output logic [BYTES_W-1:0]       bytes_o
);
    logic [1:0] target_code;

    // Pick the two code bits of the target line.
    always_comb begin
        target_code = codes_i[2*index_i +: 2];
    end

    // Expand the code to bytes.
    assign bytes_o = bin_bytes(target_code);

endmodule

// File: rtl/cline_offset_calc.sv
// Module: cline_offset_calc (top)
// Computes the byte offset of a cache line inside a compressed page and the
// line's stored size. The offset is the sum of the bin sizes of all
// preceding lines. One register stage follows the combinational tree, so
// results and valid appear the cycle after start. Results hold between
// requests. Assumes synchronous active-low reset.
module cline_offset_calc
    import cloc_pkg::*;
#(
    parameter int unsigned LINES      = 64,
    parameter int unsigned LINE_BYTES = 64
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start_i,
    input  logic [2*LINES-1:0]                     codes_i,
    input  logic [$clog2(LINES)-1:0]               index_i,
    output logic                                   valid_o,
    output logic [$clog2(LINES*LINE_BYTES)-1:0]    offset_o,
    output logic [BYTES_W-1:0]                     size_o
);
    localparam int unsigned OFF_W = $clog2(LINES*LINE_BYTES);
    localparam int unsigned SUM_W = OFF_W - 3;

    logic [ADDEND_W*LINES-1:0] addends;
    logic [SUM_W-1:0]          scaled_sum;
    logic [BYTES_W-1:0]        target_bytes;
    logic [OFF_W-1:0]          offset_d;

    cloc_mask_decode #(.LINES(LINES)) u_mask (
        .codes_i   (codes_i),
        .index_i   (index_i),
        .addends_o (addends)
    );

    cloc_adder_tree #(.LINES(LINES), .SUM_W(SUM_W)) u_tree (
        .addends_i (addends),
        .sum_o     (scaled_sum)
    );

    cloc_size_select #(.LINES(LINES)) u_size (
        .codes_i (codes_i),
        .index_i (index_i),
        .bytes_o (target_bytes)
    );

    // Undo the divide-by-eight scaling.
    assign offset_d = {scaled_sum, 3'b000};

    // Result stage: capture on start, pulse valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            offset_o <= '0;
            size_o   <= '0;
        end else begin
            valid_o <= start_i;
            if (start_i) begin
                offset_o <= offset_d;
                size_o   <= target_bytes;
            end
        end
    end

endmodule

// File: rtl/cloc_checker.sv
// Module: cloc_checker
// Protocol and range properties of cline_offset_calc, bound to the top.
module cloc_checker #(
    parameter int unsigned LINES      = 64,
    parameter int unsigned LINE_BYTES = 64
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                start_i,
    input logic [$clog2(LINES)-1:0]            index_i,
    input logic                                valid_o,
    input logic [$clog2(LINES*LINE_BYTES)-1:0] offset_o,
    input logic [6:0]                          size_o
);
    localparam int unsigned OFF_W = $clog2(LINES*LINE_BYTES);

    assert_valid_after_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (valid_o == $past(start_i)));

    assert_first_line_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(start_i) && ($past(index_i) == '0)) |-> (offset_o == '0));

    assert_offset_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((offset_o[2:0] == 3'b000) &&
                     (offset_o <= OFF_W'(32'($past(index_i)) * LINE_BYTES))));

    assert_size_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((size_o == 7'd0) || (size_o == 7'd8) ||
                     (size_o == 7'd32) || (size_o == 7'd64)));

    assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(start_i)) |-> ($stable(offset_o) && $stable(size_o)));

endmodule

bind cline_offset_calc cloc_checker #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) u_cloc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .index_i  (index_i),
    .valid_o  (valid_o),
    .offset_o (offset_o),
    .size_o   (size_o)
);

// File: tb/cline_offset_calc_bench.sv
module cline_offset_calc_bench;
    localparam int LINES = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [127:0]     codes_i = '0;
    logic [5:0]       index_i = '0;
    logic             valid_o;
    logic [11:0]      offset_o;
    logic [6:0]       size_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    cline_offset_calc u_cline_offset_calc (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .codes_i(codes_i),
        .index_i(index_i), .valid_o(valid_o), .offset_o(offset_o), .size_o(size_o)
    );

    function automatic int code_bytes(input logic [1:0] c);
        case (c)
            2'b00: return 0;
            2'b01: return 8;
            2'b10: return 32;
            default: return 64;
        endcase
    endfunction

    function automatic int ref_offset(input logic [127:0] c, input int idx);
        int acc = 0;
        for (int k = 0; k < idx; k++) acc += code_bytes(c[2*k +: 2]);
        return acc;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // One request: start for one cycle, check results, then check the hold.
    task automatic run(input logic [127:0] c, input int idx, input string req_off);
        int exp_off;
        int exp_size;
        exp_off  = ref_offset(c, idx);
        exp_size = code_bytes(c[2*idx +: 2]);
        @(negedge clk);
        codes_i = c; index_i = 6'(idx); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        codes_i = ~c;  // later changes must not disturb held results
        check("R4 valid", int'(valid_o), 1);
        check(req_off, int'(offset_o), exp_off);
        check("R1 size", int'(size_o), exp_size);
        check("R6 multiple of 8", int'(offset_o[2:0]), 0);
        @(negedge clk);
        check("R4 valid drop", int'(valid_o), 0);
        check("R5 offset hold", int'(offset_o), exp_off);
        check("R5 size hold", int'(size_o), exp_size);
    endtask

    function automatic logic [127:0] rand_codes();
        logic [127:0] v;
        for (int w = 0; w < 4; w++) v[32*w +: 32] = $urandom();
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] c;
        logic [127:0] pert;
        void'($urandom(32'h5EED_0C10));
        // R8: reset clears outputs
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 valid", int'(valid_o), 0);
        check("R8 offset", int'(offset_o), 0);
        check("R8 size", int'(size_o), 0);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // Directed pages
        run('0, 0, "R3 zero index");
        run('0, 63, "R2 empty page");
        run({128{1'b1}}, 63, "R6 full page max 4032");
        run({128{1'b1}}, 0, "R3 full page index 0");
        run({64{2'b01}}, 40, "R2 all 8B");
        run({64{2'b10}}, 17, "R2 all 32B");
        run({32{4'b1001}}, 33, "R2 alternating");
        // Random pages, every index
        for (int v = 0; v < 12; v++) begin
            c = rand_codes();
            for (int i = 0; i < LINES; i++) run(c, i, (i == 0) ? "R3 random" : "R2 random");
        end
        // R7: perturb the target line and every line after it
        for (int t = 0; t < 16; t++) begin
            int idx;
            c = rand_codes();
            idx = int'($urandom_range(0, 63));
            pert = c;
            for (int k = idx; k < LINES; k++) pert[2*k +: 2] = 2'($urandom());
            run(c, idx, "R7 base");
            run(pert, idx, "R7 perturbed");
            check("R7 same offset", ref_offset(pert, idx), ref_offset(c, idx));
        end
        finish_run();
    end
endmodule